// File: doc/BRIEF.md
# Data Address Translation Buffer

This block translates the effective addresses of loads and stores into real addresses through a small set-associative table of page translations. The page size is fixed at 4 KiB. By default there are 64 sets of 2 ways, and each way holds an effective-page tag, the real page number taken from a page-table-entry word, and a valid bit. A request is latched in one cycle and looked up in the next. The lookup result drives the response ports for as long as that request stays in the lookup stage.

The same request port also carries maintenance operations. When the maintenance flag is set, bits 11:9 of the address choose among three commands: flush the whole table, drop the one entry that matches the page, or install an entry. An installed entry takes its data from the data word. It goes into the way that already holds the page, or into the set's pseudo-LRU victim if no way holds it. A translated access that misses flags its real address as invalid and raises a one-cycle miss pulse. It does not raise an interrupt. When translation is disabled, the address passes straight through.

Top module: `xlate_dtlb`

## Requirements
- R1: After reset, no entry is valid. The miss and maintenance-done outputs are low, and the first install into any set lands in way 0.
- R2: A request with translate low gives real address = address bits 55:0, with the valid-real-address flag set, whatever the table holds.
- R3: The set index is address bits 17:12 and the tag is address bits 63:18. A lookup in another set, or with any tag bit different, does not hit.
- R4: A translated lookup that hits raises hit, reports the matching way, and gives real address = {stored entry word bits 55:12, address bits 11:0}. The other bits of the entry word have no effect.
- R5: A translated lookup that misses drives the valid-real-address flag low in its lookup cycle. It raises the miss pulse for one cycle in the next cycle.
- R6: A maintenance request with address bits 11:9 = 001 installs the page from address bits 63:12 and the entry word from the data input. If the page already hits, it rewrites the way that hit and keeps the other way unchanged.
- R7: Each set has its own pseudo-LRU state. A hit or an install in a set makes the other way that set's next victim, and an install that misses writes the victim way.
- R8: A maintenance request with bits 11:9 = 000 clears only the entry that matches its page. If nothing matches, no entry changes.
- R9: A maintenance request with bit 10 or bit 11 set clears every entry in one operation, even if bit 9 is also set.
- R10: Response ports are valid in the cycle after a request is accepted. While stall is high, the held request keeps its response, no new request is accepted, and no table update or pulse occurs.
- R11: Every accepted maintenance request produces one maintenance-done pulse, in the cycle after its lookup cycle (after the stall is released). It never raises the miss pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Hold the request in the lookup stage |
| req_valid_i | input | 1 | Request present |
| req_xlate_i | input | 1 | Translate this access through the table |
| req_maint_i | input | 1 | Request is a table maintenance command |
| req_addr_i | input | 64 | Effective address, or command and page for maintenance |
| req_data_i | input | 64 | Entry word for an install |
| rsp_hit_o | output | 1 | Lookup stage holds a valid request that hit |
| rsp_way_o | output | 1 | Way that hit |
| rsp_ra_o | output | 56 | Real address |
| rsp_ra_ok_o | output | 1 | Real address is usable |
| rsp_miss_o | output | 1 | Pulse: translated access missed |
| rsp_maint_done_o | output | 1 | Pulse: maintenance command completed |

## Verification
The bench fills a single set through a write, write, touch, write sequence. A victim choice that ignores the last touch, or that is shared between sets, would then overwrite the wrong page, and an older page would vanish. Tag and index boundaries are probed by flipping the lowest and highest tag bits and moving the page one set over. A swapped bit range would produce a false hit. Re-installing a resident page must reuse its way. A design that always wrote the victim would leave two copies, and the other way's page would be lost. Flushes are issued with bit 10 alone and with bits 11 and 9 together. A decoder that ranks install above flush would leave a valid entry. Under stall, the held response must stay frozen, a competing request must be dropped, and a held invalidate must complete exactly once after release.

// File: rtl/xdtlb_pkg.sv
// Shared definitions for the translation buffer: maintenance command codes
// and the decode of the command field carried in the request address.
// Assumes the command field sits at address bits 11:9 for every geometry.
package xdtlb_pkg;

    localparam int CMD_LSB = 9;

    typedef enum logic [1:0] {
        MC_INV_ONE = 2'd0,
        MC_WRITE   = 2'd1,
        MC_INV_ALL = 2'd2
    } maint_cmd_e;

    // Flush outranks install; install outranks single invalidate.
    function automatic maint_cmd_e decode_maint(input logic [2:0] fld);
        if (fld[2] || fld[1]) return MC_INV_ALL;
        else if (fld[0])      return MC_WRITE;
        else                  return MC_INV_ONE;
    endfunction

endpackage

// File: rtl/xdtlb_plru.sv
// Tree pseudo-LRU state for one set. Node bits point toward the victim
// half. A touch turns every node on the path away from the touched way.
// Assumes WAYS_LG >= 1. Reset points the victim at way 0.
module xdtlb_plru #(
    parameter int WAYS_LG = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_i,
    input  logic [WAYS_LG-1:0] touch_way_i,
    output logic [WAYS_LG-1:0] victim_o
);
    localparam int WAYS = 1 << WAYS_LG;

    logic [WAYS-2:0] node_q;
    logic [WAYS-2:0] node_d;

    // Follow node bits from the root to the victim leaf.
    always_comb begin
        int n;
        n = 1;
        victim_o = '0;
        for (int l = 0; l < WAYS_LG; l++) begin
            victim_o[WAYS_LG-1-l] = node_q[n-1];
            n = 2 * n + int'(node_q[n-1]);
        end
    end

    // Aim each node on the touched path at the opposite subtree.
    always_comb begin
        int n;
        n = 1;
        node_d = node_q;
        for (int l = 0; l < WAYS_LG; l++) begin
            node_d[n-1] = ~touch_way_i[WAYS_LG-1-l];
            n = 2 * n + int'(touch_way_i[WAYS_LG-1-l]);
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)       node_q <= '0;
        else if (touch_i) node_q <= node_d;
    end

    AST_VICTIM_NOT_TOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        touch_i |=> victim_o != $past(touch_way_i)); // R7

endmodule

// File: rtl/xdtlb_store.sv
// Entry storage: per-set valid bits plus tag and real-page arrays. The read
// is registered: the index presented this cycle yields data next cycle.
// Updates use single-entry write/clear ports and a one-cycle flush.
// Assumes install and flush are never requested in the same cycle.
module xdtlb_store #(
    parameter int SETS_LG = 6,
    parameter int WAYS_LG = 1,
    parameter int TAG_W   = 46,
    parameter int RPN_W   = 44
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SETS_LG-1:0]         rd_idx_i,
    output logic [(1<<WAYS_LG)-1:0]    rd_valid_o,
    output logic [(1<<WAYS_LG)-1:0][TAG_W-1:0] rd_tag_o,
    output logic [(1<<WAYS_LG)-1:0][RPN_W-1:0] rd_rpn_o,
    input  logic                       wr_en_i,
    input  logic [SETS_LG-1:0]         wr_set_i,
    input  logic [WAYS_LG-1:0]         wr_way_i,
    input  logic [TAG_W-1:0]           wr_tag_i,
    input  logic [RPN_W-1:0]           wr_rpn_i,
    input  logic                       inv_one_i,
    input  logic [WAYS_LG-1:0]         inv_way_i,
    input  logic                       inv_all_i
);
    localparam int SETS = 1 << SETS_LG;
    localparam int WAYS = 1 << WAYS_LG;

    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [TAG_W-1:0]          tag_mem [SETS][WAYS];
    logic [RPN_W-1:0]          rpn_mem [SETS][WAYS];
    logic                      any_valid;

    // Valid bits: reset/flush clear all; invalidate clears one; install sets one.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all_i) begin
            valid_q <= '0;
        end else begin
            if (inv_one_i) valid_q[wr_set_i][inv_way_i] <= 1'b0;
            if (wr_en_i)   valid_q[wr_set_i][wr_way_i]  <= 1'b1;
        end
    end

    // Tag and page arrays: written only on install.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            tag_mem[wr_set_i][wr_way_i] <= wr_tag_i;
            rpn_mem[wr_set_i][wr_way_i] <= wr_rpn_i;
        end
    end

    // Registered read of valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_o <= '0;
        else        rd_valid_o <= valid_q[rd_idx_i];
    end

    // Registered read of tags and pages.
    always_ff @(posedge clk) begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tag_o[w] <= tag_mem[rd_idx_i][w];
            rd_rpn_o[w] <= rpn_mem[rd_idx_i][w];
        end
    end

    // Occupancy summary used by the flush check.
    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all_i |=> !any_valid); // R9

    AST_INSTALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && !inv_all_i |=> valid_q[$past(wr_set_i)][$past(wr_way_i)]); // R6

endmodule

// File: rtl/xdtlb_match.sv
// Compares every way's tag with the request page and forms the real
// address. When translation is off, the low address bits pass through.
// When two ways match, the higher-numbered way is reported.
module xdtlb_match #(
    parameter int WAYS_LG = 1,
    parameter int TAG_W   = 46,
    parameter int RPN_W   = 44,
    parameter int RA_W    = 56,
    parameter int PG_LG   = 12
) (
    input  logic [(1<<WAYS_LG)-1:0]             rd_valid_i,
    input  logic [(1<<WAYS_LG)-1:0][TAG_W-1:0]  rd_tag_i,
    input  logic [(1<<WAYS_LG)-1:0][RPN_W-1:0]  rd_rpn_i,
    input  logic [TAG_W-1:0]                    ea_tag_i,
    input  logic [RA_W-1:0]                     ea_low_i,
    input  logic                                xlate_i,
    output logic                                hit_o,
    output logic [WAYS_LG-1:0]                  hit_way_o,
    output logic [RA_W-1:0]                     ra_o,
    output logic                                ra_ok_o
);
    localparam int WAYS = 1 << WAYS_LG;

    // Parallel tag compare, last match wins.
    always_comb begin
        hit_o     = 1'b0;
        hit_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rd_valid_i[w] && rd_tag_i[w] == ea_tag_i) begin
                hit_o     = 1'b1;
                hit_way_o = WAYS_LG'(w);
            end
        end
    end

    // Real address select and usability.
    always_comb begin
        if (xlate_i) ra_o = {rd_rpn_i[hit_way_o], ea_low_i[PG_LG-1:0]};
        else         ra_o = ea_low_i;
        ra_ok_o = !xlate_i || hit_o;
    end

endmodule

// File: rtl/xlate_dtlb.sv
// Data translation buffer top. Stage 0 latches the request. Stage 1 looks
// it up against the registered table read and applies maintenance updates
// at the end of the cycle. Completion pulses are registered one cycle
// later. Assumes the requester leaves one idle cycle after a maintenance
// command before a lookup to the same set, because the table read is
// registered.
module xlate_dtlb #(
    parameter int VA_W    = 64,
    parameter int RA_W    = 56,
    parameter int PG_LG   = 12,
    parameter int SETS_LG = 6,
    parameter int WAYS_LG = 1,
    parameter int PTE_W   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_i,
    input  logic               req_valid_i,
    input  logic               req_xlate_i,
    input  logic               req_maint_i,
    input  logic [VA_W-1:0]    req_addr_i,
    input  logic [PTE_W-1:0]   req_data_i,
    output logic               rsp_hit_o,
    output logic [WAYS_LG-1:0] rsp_way_o,
    output logic [RA_W-1:0]    rsp_ra_o,
    output logic               rsp_ra_ok_o,
    output logic               rsp_miss_o,
    output logic               rsp_maint_done_o
);
    import xdtlb_pkg::*;

    localparam int SETS   = 1 << SETS_LG;
    localparam int WAYS   = 1 << WAYS_LG;
    localparam int TAG_LO = PG_LG + SETS_LG;
    localparam int TAG_W  = VA_W - TAG_LO;
    localparam int RPN_W  = RA_W - PG_LG;

    logic               r0_valid, r0_xlate, r0_maint;
    logic [VA_W-1:0]    r0_addr;
    logic [RPN_W-1:0]   r0_rpn;
    logic [SETS_LG-1:0] r0_idx, rd_idx;

    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0][RPN_W-1:0]  rd_rpn;

    logic               hit_raw, ra_ok, act;
    logic [WAYS_LG-1:0] hit_way, fill_way;
    logic [RA_W-1:0]    ra;
    maint_cmd_e         cmd;
    logic               wr_en, inv_one, inv_all;
    logic [SETS-1:0][WAYS_LG-1:0] victims;
    logic               done_q, miss_q;

    // Stage 0 valid: cleared by reset, held while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n)        r0_valid <= 1'b0;
        else if (!stall_i) r0_valid <= req_valid_i;
    end

    // Stage 0 payload, held while stalled.
    always_ff @(posedge clk) begin
        if (!stall_i) begin
            r0_xlate <= req_xlate_i;
            r0_maint <= req_maint_i;
            r0_addr  <= req_addr_i;
            r0_rpn   <= req_data_i[RA_W-1:PG_LG];
        end
    end

    assign r0_idx = r0_addr[TAG_LO-1:PG_LG];
    // Read index: re-read the held request while stalled.
    assign rd_idx = stall_i ? r0_idx : req_addr_i[TAG_LO-1:PG_LG];

    xdtlb_store #(.SETS_LG(SETS_LG), .WAYS_LG(WAYS_LG), .TAG_W(TAG_W), .RPN_W(RPN_W)) store_i (
        .clk(clk), .rst_n(rst_n), .rd_idx_i(rd_idx),
        .rd_valid_o(rd_valid), .rd_tag_o(rd_tag), .rd_rpn_o(rd_rpn),
        .wr_en_i(wr_en), .wr_set_i(r0_idx), .wr_way_i(fill_way),
        .wr_tag_i(r0_addr[VA_W-1:TAG_LO]), .wr_rpn_i(r0_rpn),
        .inv_one_i(inv_one), .inv_way_i(hit_way), .inv_all_i(inv_all)
    );

    xdtlb_match #(.WAYS_LG(WAYS_LG), .TAG_W(TAG_W), .RPN_W(RPN_W), .RA_W(RA_W), .PG_LG(PG_LG)) match_i (
        .rd_valid_i(rd_valid), .rd_tag_i(rd_tag), .rd_rpn_i(rd_rpn),
        .ea_tag_i(r0_addr[VA_W-1:TAG_LO]), .ea_low_i(r0_addr[RA_W-1:0]),
        .xlate_i(r0_xlate), .hit_o(hit_raw), .hit_way_o(hit_way),
        .ra_o(ra), .ra_ok_o(ra_ok)
    );

    // Maintenance decode and update strobes for the stage 1 request.
    always_comb begin
        cmd      = decode_maint(r0_addr[CMD_LSB+2:CMD_LSB]);
        act      = r0_valid && r0_maint && !stall_i;
        fill_way = hit_raw ? hit_way : victims[r0_idx];
        wr_en    = act && cmd == MC_WRITE;
        inv_one  = act && cmd == MC_INV_ONE && hit_raw;
        inv_all  = act && cmd == MC_INV_ALL;
    end

    // One replacement state per set, touched on hit or install.
    for (genvar s = 0; s < SETS; s++) begin : g_set_plru
        logic touch;
        assign touch = (r0_idx == SETS_LG'(s)) && ((r0_valid && hit_raw) || wr_en);
        xdtlb_plru #(.WAYS_LG(WAYS_LG)) plru_i (
            .clk(clk), .rst_n(rst_n), .touch_i(touch),
            .touch_way_i(fill_way), .victim_o(victims[s])
        );
    end

    // Completion pulses, one cycle after the lookup cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            done_q <= act;
            miss_q <= r0_valid && !r0_maint && r0_xlate && !hit_raw && !stall_i;
        end
    end

    assign rsp_hit_o        = r0_valid && hit_raw;
    assign rsp_way_o        = hit_way;
    assign rsp_ra_o         = ra;
    assign rsp_ra_ok_o      = ra_ok;
    assign rsp_miss_o       = miss_q;
    assign rsp_maint_done_o = done_q;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && !req_maint_i && !req_xlate_i && !stall_i
        |=> rsp_ra_ok_o && rsp_ra_o == $past(req_addr_i[RA_W-1:0])); // R2

    AST_MISS_BAD_RA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss_o |-> $past(!rsp_ra_ok_o)); // R5

    AST_MAINT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_i && $past(rst_n) && $past(req_valid_i && req_maint_i && !stall_i)
        |=> rsp_maint_done_o); // R11

    AST_DONE_NOT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_maint_done_o |-> !rsp_miss_o); // R11

    AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i && $past(stall_i) && $past(rst_n)
        |-> $stable(rsp_ra_o) && $stable(rsp_hit_o) && !rsp_maint_done_o); // R10

endmodule

// File: tb/xlate_dtlb_tb_top.sv
// Directed bench for the translation buffer: one task per scenario.
module xlate_dtlb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        req_valid = 1'b0, req_xlate = 1'b0, req_maint = 1'b0;
    logic [63:0] req_addr = '0, req_data = '0;
    logic        rsp_hit, rsp_ra_ok, rsp_miss, rsp_done;
    logic [0:0]  rsp_way;
    logic [55:0] rsp_ra;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    logic        o_hit, o_ok, o_done, o_miss;
    logic [0:0]  o_way;
    logic [55:0] o_ra;

    always #5 clk = ~clk;

    xlate_dtlb dut_i (
        .clk(clk), .rst_n(rst_n), .stall_i(stall),
        .req_valid_i(req_valid), .req_xlate_i(req_xlate), .req_maint_i(req_maint),
        .req_addr_i(req_addr), .req_data_i(req_data),
        .rsp_hit_o(rsp_hit), .rsp_way_o(rsp_way), .rsp_ra_o(rsp_ra),
        .rsp_ra_ok_o(rsp_ra_ok), .rsp_miss_o(rsp_miss), .rsp_maint_done_o(rsp_done)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] ea(input logic [45:0] t, input logic [5:0] s, input logic [11:0] o);
        return {t, s, o};
    endfunction

    function automatic logic [63:0] pte(input logic [43:0] rpn);
        return {8'hC3, rpn, 12'h96F};
    endfunction

    // One request, one idle cycle; captures lookup and pulse results.
    task automatic issue(input logic m, input logic x, input logic [63:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_maint = m; req_xlate = x; req_addr = a; req_data = d;
        @(negedge clk);
        o_hit = rsp_hit; o_way = rsp_way; o_ra = rsp_ra; o_ok = rsp_ra_ok;
        req_valid = 1'b0;
        @(negedge clk);
        o_done = rsp_done; o_miss = rsp_miss;
    endtask

    task automatic install(input logic [45:0] t, input logic [5:0] s, input logic [43:0] rpn);
        issue(1'b1, 1'b0, ea(t, s, 12'h200), pte(rpn));
        chk("R11 install done", o_done, 1);
        chk("R11 install no miss", o_miss, 0);
    endtask

    task automatic expect_hit(input string rq, input logic [45:0] t, input logic [5:0] s,
                              input logic [11:0] off, input logic w, input logic [43:0] rpn);
        issue(1'b0, 1'b1, ea(t, s, off), 64'h0);
        chk({rq, " hit"}, o_hit, 1);
        chk({rq, " way"}, o_way, w);
        chk({rq, " ra"}, o_ra, {rpn, off});
        chk({rq, " ok"}, o_ok, 1);
        chk({rq, " no miss"}, o_miss, 0);
    endtask

    task automatic expect_miss(input string rq, input logic [45:0] t, input logic [5:0] s);
        issue(1'b0, 1'b1, ea(t, s, 12'h010), 64'h0);
        chk({rq, " hit"}, o_hit, 0);
        chk({rq, " ok"}, o_ok, 0);
        chk({rq, " miss pulse"}, o_miss, 1);
    endtask

    task automatic t_reset;
        chk("R1 done low", rsp_done, 0);
        chk("R1 miss low", rsp_miss, 0);
        expect_miss("R1 empty table", 46'h123, 6'd1);
    endtask

    task automatic t_pass_through;
        issue(1'b0, 1'b0, 64'hFEDC_BA98_7654_3210, 64'h0);
        chk("R2 ra", o_ra, 56'hDC_BA98_7654_3210);
        chk("R2 ok", o_ok, 1);
        chk("R2 no miss", o_miss, 0);
    endtask

    task automatic t_install_hit;
        install(46'h123, 6'd1, 44'hA_BCDE_0123);
        expect_hit("R4 R1 first fill way0", 46'h123, 6'd1, 12'hABC, 1'b0, 44'hA_BCDE_0123);
        issue(1'b0, 1'b0, ea(46'h123, 6'd1, 12'h004), 64'h0);
        chk("R2 xlate off ignores entry", o_ra, ea(46'h123, 6'd1, 12'h004) & 64'h00FF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_geometry;
        expect_miss("R3 other set", 46'h123, 6'd2);
        expect_miss("R3 tag lsb", 46'h122, 6'd1);
        expect_miss("R3 tag msb", 46'h2000_0000_0123, 6'd1);
    endtask

    task automatic t_replace;
        install(46'h51, 6'd5, 44'h1_1111);
        expect_hit("R7 T1 way0", 46'h51, 6'd5, 12'h001, 1'b0, 44'h1_1111);
        install(46'h52, 6'd5, 44'h2_2222);
        expect_hit("R7 T2 way1", 46'h52, 6'd5, 12'h002, 1'b1, 44'h2_2222);
        expect_hit("R7 T1 touch", 46'h51, 6'd5, 12'h003, 1'b0, 44'h1_1111);
        install(46'h53, 6'd5, 44'h3_3333);
        expect_miss("R7 T2 evicted", 46'h52, 6'd5);
        expect_hit("R7 T1 kept", 46'h51, 6'd5, 12'h004, 1'b0, 44'h1_1111);
        expect_hit("R7 T3 way1", 46'h53, 6'd5, 12'h005, 1'b1, 44'h3_3333);
        expect_hit("R7 set1 untouched", 46'h123, 6'd1, 12'h006, 1'b0, 44'hA_BCDE_0123);
    endtask

    task automatic t_rewrite;
        install(46'h51, 6'd5, 44'h9_9999);
        expect_hit("R6 reuse hit way", 46'h51, 6'd5, 12'h7F0, 1'b0, 44'h9_9999);
        expect_hit("R6 other way kept", 46'h53, 6'd5, 12'h7F1, 1'b1, 44'h3_3333);
    endtask

    task automatic t_inv_one;
        issue(1'b1, 1'b0, ea(46'h53, 6'd5, 12'h000), 64'h0);
        chk("R11 inv done", o_done, 1);
        chk("R11 inv no miss", o_miss, 0);
        expect_miss("R8 target gone", 46'h53, 6'd5);
        expect_hit("R8 neighbour kept", 46'h51, 6'd5, 12'h020, 1'b0, 44'h9_9999);
        issue(1'b1, 1'b0, ea(46'h99, 6'd5, 12'h000), 64'h0);
        chk("R8 absent page done", o_done, 1);
        expect_hit("R8 no-op on miss", 46'h51, 6'd5, 12'h021, 1'b0, 44'h9_9999);
    endtask

    task automatic t_inv_all;
        issue(1'b1, 1'b0, ea(46'h0, 6'd0, 12'h400), 64'h0);
        chk("R9 flush done", o_done, 1);
        expect_miss("R9 set5 flushed", 46'h51, 6'd5);
        expect_miss("R9 set1 flushed", 46'h123, 6'd1);
        install(46'h123, 6'd1, 44'h4_4444);
        issue(1'b1, 1'b0, ea(46'h77, 6'd9, 12'hA00), pte(44'h5_5555));
        chk("R9 bit11 done", o_done, 1);
        expect_miss("R9 bit11 flushed", 46'h123, 6'd1);
        expect_miss("R9 flush beats install", 46'h77, 6'd9);
    endtask

    task automatic t_stall;
        install(46'h77, 6'd7, 44'h7_7777);
        @(negedge clk);
        req_valid = 1'b1; req_maint = 1'b0; req_xlate = 1'b1; req_addr = ea(46'h77, 6'd7, 12'h123);
        @(negedge clk);
        chk("R10 held hit", rsp_hit, 1);
        stall = 1'b1; req_addr = ea(46'h66, 6'd7, 12'h456);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 stalled hit", rsp_hit, 1);
            chk("R10 stalled ra", rsp_ra, {44'h7_7777, 12'h123});
            chk("R10 stalled no miss", rsp_miss, 0);
        end
        stall = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk("R10 competing request dropped", rsp_hit, 0);
        chk("R10 no miss after release", rsp_miss, 0);
        req_valid = 1'b1; req_maint = 1'b1; req_xlate = 1'b0; req_addr = ea(46'h77, 6'd7, 12'h000);
        @(negedge clk);
        stall = 1'b1; req_valid = 1'b0;
        chk("R10 inv held sees hit", rsp_hit, 1);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R11 no done while stalled", rsp_done, 0);
        end
        stall = 1'b0;
        @(negedge clk);
        chk("R11 done after release", rsp_done, 1);
        @(negedge clk);
        chk("R11 single done pulse", rsp_done, 0);
        expect_miss("R10 held inv applied", 46'h77, 6'd7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass_through();
        t_install_hit();
        t_geometry();
        t_replace();
        t_rewrite();
        t_inv_one();
        t_inv_all();
        t_stall();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule